// File: doc/BRIEF.md
# Counter Flag and Interrupt Router

This block sits between a bank of position counters and the host. For each channel it takes the counter's raw event pulses (carry, borrow, compare match, error) and its live direction and index levels. From these it builds two configurable flag outputs per channel. A per-channel 2-bit mode code chooses what the two flags carry. One setting is the cascade form: the first flag pulses on carry or borrow and the second follows the count direction. That pair drives the count input of the next counter in a chain.

A global routing byte does two jobs for every channel. Its low half steers the index input to either the counter's load input or its reset/gate input. Its high half picks which of the two flags feeds the channel's interrupt source. A rising edge on the chosen flag sets a sticky pending bit. Each pending bit can be masked, and the host clears it by writing a one. A single host interrupt line is raised while any unmasked pending bit is set. The line has an enable, a polarity control and a level/edge mode, and edge mode has a clear strobe. No vector is produced, so the host polls the pending bits to find the source.

Each channel also keeps a readable status byte. It holds three toggle bits, a sign bit, a sticky error bit, and the sampled direction and index levels. The toggle and sign bits are cleared by one reset path and the error bit by another.

Top module: `cntflag_irq_router`

## Requirements
- R1: The per-channel mode code sets the two flags. The flags are registered and appear one cycle after the inputs. Code 0 gives flag1 = carry and flag2 = borrow. Code 1 gives flag1 = compare and flag2 = borrow. Code 2 gives flag1 = carry OR borrow and flag2 = the direction input (1 = up). Code 3 gives flag1 = the index level and flag2 = the sticky error bit, taking the error bit's value after the same clock edge.
- R2: In code 2 the flag pair forms the cascade output. A one-cycle carry or borrow event gives a one-cycle flag1 pulse, and flag2 shows up (1) or down (0).
- R3: Bit i of route_cfg sends channel i's index to the load output when it is 1 and to the reset/gate output when it is 0. The unselected output stays 0. These outputs are combinational.
- R4: Bit NCH+i of route_cfg picks channel i's interrupt source: 0 = flag1, 1 = flag2. On the clock edge where the selected flag goes from 0 to 1, the channel's pending bit is set.
- R5: Writing a one to a bit of pend_clr clears that pending bit on the next edge. If a new rising edge arrives in the same cycle, the set wins.
- R6: A mask bit of 1 stops its pending bit from driving the host line. The pending bit itself is still set and can still be read.
- R7: In level mode (irq_edge = 0), the line is active when irq_en = 1 and any unmasked pending bit is set. Active means high when irq_pol = 1 and low when irq_pol = 0.
- R8: In edge mode (irq_edge = 1), a rise of the enabled, unmasked pending condition sets a latch on the next edge. The latch holds even after the pending bits clear, until an irq_clr strobe clears it. A set in the same cycle as a clear wins over the clear. Leaving edge mode clears the latch. The line shows the latch, inverted when irq_pol = 0.
- R9: The status byte for the channel chosen by status_sel has this bit order, from bit 0: borrow toggle, carry toggle, compare toggle, sign, error, direction, index. Bit 7 is always 0. Direction and index are sampled each clock.
- R10: Each borrow event inverts the borrow toggle. Each carry event inverts the carry toggle. Each compare event inverts the compare toggle. A borrow sets the sign bit and a carry clears it; if both arrive together, the borrow wins.
- R11: flag_clr clears the borrow, carry and compare toggles and the sign bit, and it takes priority over events in the same cycle. It leaves the error bit alone. The error bit is set by an error event and cleared only by err_clr, which takes priority.
- R12: After reset, all flags, pending bits, status bits and the edge latch are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_carry | input | NCH | Carry event pulse per channel |
| ev_borrow | input | NCH | Borrow event pulse per channel |
| ev_compare | input | NCH | Compare-match pulse per channel |
| ev_error | input | NCH | Error event pulse per channel |
| dir_up | input | NCH | Count direction level, 1 = up |
| idx_in | input | NCH | Index level per channel |
| flag_mode | input | 2*NCH | Flag mode code, channel i at bits 2i+1:2i |
| route_cfg | input | 2*NCH | Index routes (low half) and interrupt source selects (high half) |
| flag_clr | input | NCH | Clear toggles and sign per channel |
| err_clr | input | NCH | Clear the error bit per channel |
| pend_clr | input | NCH | Write-one clear of pending bits |
| irq_mask | input | NCH | Pending mask, 1 = masked |
| irq_en | input | 1 | Host interrupt enable |
| irq_pol | input | 1 | Host line polarity, 1 = active high |
| irq_edge | input | 1 | 1 = edge mode, 0 = level mode |
| irq_clr | input | 1 | Edge latch clear strobe |
| status_sel | input | SELW | Channel whose status byte is shown |
| flg1_o | output | NCH | Flag 1 per channel |
| flg2_o | output | NCH | Flag 2 per channel |
| idx_load_o | output | NCH | Index routed to the counter load input |
| idx_reset_o | output | NCH | Index routed to the counter reset/gate input |
| pend_o | output | NCH | Pending interrupt bits |
| status_o | output | 8 | Status byte of the selected channel |
| irq_o | output | 1 | Host interrupt line |

## Verification
The in-line assertions run on every cycle. They check these points: a flag reset leaves the toggles and sign at zero, and the error bit survives everything except its own clear. A rising selected flag always produces a pending bit, and a pending bit without a clear does not vanish. A masked, idle level-mode line stays at its inactive level. The edge latch holds until it is cleared. Other behaviour only shows up in the bench's scenarios: the flag mux contents for each mode code, the cascade pulse shape, the exact status byte values after event sequences, the set-over-clear race on pending bits, and the sequence in which the edge latch outlives its source.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

    typedef enum logic [1:0] {
        FM_CARRY_BORROW   = 2'd0,
        FM_COMPARE_BORROW = 2'd1,
        FM_CASCADE        = 2'd2,
        FM_INDEX_ERROR    = 2'd3
    } flag_mode_e;

    typedef struct packed {
        logic bt;
        logic ct;
        logic cpt;
        logic sgn;
        logic err;
        logic ud;
        logic ix;
        logic flg1;
        logic flg2;
        logic pend;
    } chan_st_t;

    typedef struct packed {
        logic latch;
        logic act_prev;
    } irq_st_t;

    function automatic logic [7:0] pack_status(chan_st_t s);
        return {1'b0, s.ix, s.ud, s.err, s.sgn, s.cpt, s.ct, s.bt};
    endfunction

endpackage

// File: rtl/cfir_chan.sv
module cfir_chan
    import cfir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_carry,
    input  logic       ev_borrow,
    input  logic       ev_compare,
    input  logic       ev_error,
    input  logic       dir_up,
    input  logic       idx_in,
    input  logic [1:0] mode,
    input  logic       src_sel,
    input  logic       flag_clr,
    input  logic       err_clr,
    input  logic       pend_clr,
    output logic       flg1_o,
    output logic       flg2_o,
    output logic       pend_o,
    output logic [7:0] status_o
);

    chan_st_t st_d, st_q;
    logic     sel_d;
    logic     sel_cur;

    always_comb begin
        st_d = st_q;

        if (flag_clr) begin
            st_d.bt  = 1'b0;
            st_d.ct  = 1'b0;
            st_d.cpt = 1'b0;
            st_d.sgn = 1'b0;
        end else begin
            st_d.bt  = st_q.bt  ^ ev_borrow;
            st_d.ct  = st_q.ct  ^ ev_carry;
            st_d.cpt = st_q.cpt ^ ev_compare;
            if (ev_borrow)
                st_d.sgn = 1'b1;
            else if (ev_carry)
                st_d.sgn = 1'b0;
        end

        st_d.err = err_clr ? 1'b0 : (st_q.err | ev_error);
        st_d.ud  = dir_up;
        st_d.ix  = idx_in;

        unique case (flag_mode_e'(mode))
            FM_CARRY_BORROW: begin
                st_d.flg1 = ev_carry;
                st_d.flg2 = ev_borrow;
            end
            FM_COMPARE_BORROW: begin
                st_d.flg1 = ev_compare;
                st_d.flg2 = ev_borrow;
            end
            FM_CASCADE: begin
                st_d.flg1 = ev_carry | ev_borrow;
                st_d.flg2 = dir_up;
            end
            default: begin
                st_d.flg1 = idx_in;
                st_d.flg2 = st_d.err;
            end
        endcase

        sel_d   = src_sel ? st_d.flg2 : st_d.flg1;
        sel_cur = src_sel ? st_q.flg2 : st_q.flg1;
        st_d.pend = (st_q.pend & ~pend_clr) | (sel_d & ~sel_cur);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flg1_o   = st_q.flg1;
    assign flg2_o   = st_q.flg2;
    assign pend_o   = st_q.pend;
    assign status_o = pack_status(st_q);

    // R11: flag reset leaves toggles and sign at zero
    a_r11_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!st_q.bt && !st_q.ct && !st_q.cpt && !st_q.sgn));

    // R11: error bit only leaves through its own clear
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !err_clr) |=> st_q.err);

    // R4: a rising selected flag always produces a pending bit
    a_r4_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_d && !sel_cur) |=> pend_o);

    // R5: a pending bit is kept until written with one
    a_r5_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !pend_clr) |=> pend_o);

endmodule

// File: rtl/cfir_irq.sv
module cfir_irq
    import cfir_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    input  logic [NCH-1:0] mask,
    input  logic           irq_en,
    input  logic           irq_pol,
    input  logic           irq_edge,
    input  logic           irq_clr,
    output logic           irq_o
);

    irq_st_t st_d, st_q;
    logic    active;

    always_comb begin
        active = irq_en & (|(pend & ~mask));
        st_d   = st_q;
        st_d.act_prev = active;
        if (!irq_edge)
            st_d.latch = 1'b0;
        else if (active && !st_q.act_prev)
            st_d.latch = 1'b1;
        else if (irq_clr)
            st_d.latch = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        if (irq_edge)
            irq_o = irq_pol ? st_q.latch : ~st_q.latch;
        else
            irq_o = irq_pol ? active : ~active;
    end

    // R8: the edge latch outlives its source until cleared
    a_r8_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_edge && st_q.latch && !irq_clr) |=> (!irq_edge || st_q.latch));

    // R6: with all pending bits masked the level line sits inactive
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_edge && ((pend & ~mask) == '0)) |-> (irq_o == !irq_pol));

endmodule

// File: rtl/cntflag_irq_router.sv
module cntflag_irq_router
    import cfir_pkg::*;
#(
    parameter  int NCH  = 4,
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ev_carry,
    input  logic [NCH-1:0]   ev_borrow,
    input  logic [NCH-1:0]   ev_compare,
    input  logic [NCH-1:0]   ev_error,
    input  logic [NCH-1:0]   dir_up,
    input  logic [NCH-1:0]   idx_in,
    input  logic [2*NCH-1:0] flag_mode,
    input  logic [2*NCH-1:0] route_cfg,
    input  logic [NCH-1:0]   flag_clr,
    input  logic [NCH-1:0]   err_clr,
    input  logic [NCH-1:0]   pend_clr,
    input  logic [NCH-1:0]   irq_mask,
    input  logic             irq_en,
    input  logic             irq_pol,
    input  logic             irq_edge,
    input  logic             irq_clr,
    input  logic [SELW-1:0]  status_sel,
    output logic [NCH-1:0]   flg1_o,
    output logic [NCH-1:0]   flg2_o,
    output logic [NCH-1:0]   idx_load_o,
    output logic [NCH-1:0]   idx_reset_o,
    output logic [NCH-1:0]   pend_o,
    output logic [7:0]       status_o,
    output logic             irq_o
);

    logic [NCH-1:0][7:0] chan_status;
    logic [NCH-1:0]      idx_route;
    logic [NCH-1:0]      src_route;

    assign idx_route = route_cfg[NCH-1:0];
    assign src_route = route_cfg[2*NCH-1:NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        cfir_chan i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_carry   (ev_carry[i]),
            .ev_borrow  (ev_borrow[i]),
            .ev_compare (ev_compare[i]),
            .ev_error   (ev_error[i]),
            .dir_up     (dir_up[i]),
            .idx_in     (idx_in[i]),
            .mode       (flag_mode[2*i +: 2]),
            .src_sel    (src_route[i]),
            .flag_clr   (flag_clr[i]),
            .err_clr    (err_clr[i]),
            .pend_clr   (pend_clr[i]),
            .flg1_o     (flg1_o[i]),
            .flg2_o     (flg2_o[i]),
            .pend_o     (pend_o[i]),
            .status_o   (chan_status[i])
        );
    end

    assign idx_load_o  = idx_in &  idx_route;
    assign idx_reset_o = idx_in & ~idx_route;

    always_comb begin
        status_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (status_sel == SELW'(i))
                status_o = chan_status[i];
        end
    end

    cfir_irq #(.NCH(NCH)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend_o),
        .mask     (irq_mask),
        .irq_en   (irq_en),
        .irq_pol  (irq_pol),
        .irq_edge (irq_edge),
        .irq_clr  (irq_clr),
        .irq_o    (irq_o)
    );

    // R3: an index never reaches both counter inputs
    a_r3_route_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idx_load_o[0], idx_reset_o[0]}));

    // R9: the top status bit always reads zero
    a_r9_status_msb: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[7]);

endmodule

// File: tb/test_cntflag_irq_router.sv
module test_cntflag_irq_router;

    localparam int NCH  = 4;
    localparam int SELW = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NCH-1:0]   ev_carry, ev_borrow, ev_compare, ev_error, dir_up, idx_in;
    logic [2*NCH-1:0] flag_mode, route_cfg;
    logic [NCH-1:0]   flag_clr, err_clr, pend_clr, irq_mask;
    logic             irq_en, irq_pol, irq_edge, irq_clr;
    logic [SELW-1:0]  status_sel;
    logic [NCH-1:0]   flg1_o, flg2_o, idx_load_o, idx_reset_o, pend_o;
    logic [7:0]       status_o;
    logic             irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [NCH-1:0] m_bt, m_ct, m_cpt, m_s, m_e, m_ud, m_ix, m_f1, m_f2, m_pend;
    logic           m_latch, m_prev;

    always #4 clk = ~clk;

    cntflag_irq_router #(.NCH(NCH)) i_cntflag_irq_router (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_flags(logic [1:0] m, logic c, logic b, logic cp,
                                             logic up, logic ix, logic e);
        case (m)
            2'd0:    return {c, b};
            2'd1:    return {cp, b};
            2'd2:    return {c | b, up};
            default: return {ix, e};
        endcase
    endfunction

    function automatic logic exp_active();
        return irq_en & (|(m_pend & ~irq_mask));
    endfunction

    function automatic logic exp_irq();
        if (irq_edge) return irq_pol ? m_latch : ~m_latch;
        return irq_pol ? exp_active() : ~exp_active();
    endfunction

    function automatic logic [7:0] exp_status(int c);
        return {1'b0, m_ix[c], m_ud[c], m_e[c], m_s[c], m_cpt[c], m_ct[c], m_bt[c]};
    endfunction

    task automatic model_clear();
        {m_bt, m_ct, m_cpt, m_s, m_e, m_ud, m_ix, m_f1, m_f2, m_pend} = '0;
        m_latch = 1'b0;
        m_prev  = 1'b0;
    endtask

    task automatic cycle();
        logic [NCH-1:0] n_bt, n_ct, n_cpt, n_s, n_e, n_f1, n_f2, n_pend;
        logic [1:0] fl;
        logic sel_n, sel_c, act, n_latch;
        for (int i = 0; i < NCH; i++) begin
            n_bt[i]  = flag_clr[i] ? 1'b0 : m_bt[i]  ^ ev_borrow[i];
            n_ct[i]  = flag_clr[i] ? 1'b0 : m_ct[i]  ^ ev_carry[i];
            n_cpt[i] = flag_clr[i] ? 1'b0 : m_cpt[i] ^ ev_compare[i];
            n_s[i]   = flag_clr[i] ? 1'b0 : ev_borrow[i] ? 1'b1 : ev_carry[i] ? 1'b0 : m_s[i];
            n_e[i]   = err_clr[i] ? 1'b0 : (m_e[i] | ev_error[i]);
            fl = exp_flags(flag_mode[2*i +: 2], ev_carry[i], ev_borrow[i], ev_compare[i],
                           dir_up[i], idx_in[i], n_e[i]);
            n_f1[i] = fl[1];
            n_f2[i] = fl[0];
            sel_n = route_cfg[NCH+i] ? n_f2[i] : n_f1[i];
            sel_c = route_cfg[NCH+i] ? m_f2[i] : m_f1[i];
            n_pend[i] = (m_pend[i] & ~pend_clr[i]) | (sel_n & ~sel_c);
        end
        act = exp_active();
        if (!irq_edge) n_latch = 1'b0;
        else if (act && !m_prev) n_latch = 1'b1;
        else if (irq_clr) n_latch = 1'b0;
        else n_latch = m_latch;
        @(posedge clk);
        #2;
        m_bt = n_bt; m_ct = n_ct; m_cpt = n_cpt; m_s = n_s; m_e = n_e;
        m_ud = dir_up; m_ix = idx_in; m_f1 = n_f1; m_f2 = n_f2; m_pend = n_pend;
        m_latch = n_latch; m_prev = act;
        chk("R1 flag1", 32'(flg1_o), 32'(m_f1));
        chk("R1 flag2", 32'(flg2_o), 32'(m_f2));
        chk("R3 index load", 32'(idx_load_o), 32'(idx_in & route_cfg[NCH-1:0]));
        chk("R3 index reset", 32'(idx_reset_o), 32'(idx_in & ~route_cfg[NCH-1:0]));
        chk("R4 pending", 32'(pend_o), 32'(m_pend));
        chk("R9 status", 32'(status_o), 32'(exp_status(int'(status_sel))));
        chk("R7 host line", 32'(irq_o), 32'(exp_irq()));
    endtask

    task automatic quiet();
        ev_carry = '0; ev_borrow = '0; ev_compare = '0; ev_error = '0;
        flag_clr = '0; err_clr = '0; pend_clr = '0; irq_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd24681);
        rst_n = 1'b0;
        quiet();
        dir_up = '0; idx_in = '0; flag_mode = '0; route_cfg = '0;
        irq_mask = '0; irq_en = 1'b0; irq_pol = 1'b1; irq_edge = 1'b0;
        status_sel = '0;
        model_clear();
        repeat (3) @(posedge clk);
        #2;
        chk("R12 reset pending", 32'(pend_o), 0);
        chk("R12 reset flags", 32'({flg1_o, flg2_o}), 0);
        chk("R12 reset status", 32'(status_o), 0);
        chk("R12 reset line", 32'(irq_o), 0);
        rst_n = 1'b1;
        cycle();

        // R3 directed index routing
        route_cfg = 8'h01; idx_in = 4'b0011;
        cycle();
        chk("R3 ch0 to load", 32'({idx_load_o[0], idx_reset_o[0]}), 32'b10);
        chk("R3 ch1 to reset", 32'({idx_load_o[1], idx_reset_o[1]}), 32'b01);
        idx_in = '0; route_cfg = '0;
        cycle();

        // R2 cascade form on channel 1
        flag_mode = 8'b0000_1000;
        dir_up[1] = 1'b1; ev_carry[1] = 1'b1;
        cycle();
        chk("R2 carry pulse up", 32'({flg1_o[1], flg2_o[1]}), 32'b11);
        ev_carry[1] = 1'b0; ev_borrow[1] = 1'b1; dir_up[1] = 1'b0;
        cycle();
        chk("R2 borrow pulse down", 32'({flg1_o[1], flg2_o[1]}), 32'b10);
        quiet();
        cycle();
        chk("R2 pulse ends", 32'(flg1_o[1]), 0);

        // R10/R11 status sequence on channel 2
        status_sel = 2'd2;
        ev_borrow[2] = 1'b1;
        cycle();
        chk("R10 borrow toggles and sets sign", 32'(status_o), 32'h09);
        cycle();
        chk("R10 second borrow toggles back", 32'(status_o), 32'h08);
        quiet(); ev_carry[2] = 1'b1;
        cycle();
        chk("R10 carry toggles and clears sign", 32'(status_o), 32'h02);
        quiet(); ev_error[2] = 1'b1;
        cycle();
        chk("R11 error set", 32'(status_o), 32'h12);
        quiet(); flag_clr[2] = 1'b1; ev_borrow[2] = 1'b1;
        cycle();
        chk("R11 flag reset keeps error", 32'(status_o), 32'h10);
        quiet(); err_clr[2] = 1'b1; ev_error[2] = 1'b1;
        cycle();
        chk("R11 error clear wins", 32'(status_o), 32'h00);
        quiet(); ev_compare[2] = 1'b1; dir_up[2] = 1'b1; idx_in[2] = 1'b1;
        cycle();
        chk("R9 bit order", 32'(status_o), 32'h64);
        quiet(); flag_clr[2] = 1'b1; dir_up[2] = 1'b0; idx_in[2] = 1'b0;
        cycle();
        chk("R9 cleared", 32'(status_o), 32'h00);

        // R5 set wins over clear
        quiet(); pend_clr = '1; ev_carry[3] = 1'b1;
        cycle();
        chk("R5 set beats clear", 32'(pend_o), 32'b1000);
        quiet(); pend_clr = '1;
        cycle();
        chk("R5 write-one clear", 32'(pend_o), 0);

        // R6 / R7 mask and level polarity
        quiet(); irq_en = 1'b1; irq_pol = 1'b1; irq_mask = 4'b1000; ev_carry[3] = 1'b1;
        cycle();
        chk("R6 masked pending kept", 32'(pend_o[3]), 1);
        chk("R6 masked line quiet", 32'(irq_o), 0);
        quiet(); irq_mask = '0;
        cycle();
        chk("R7 level active high", 32'(irq_o), 1);
        irq_pol = 1'b0;
        cycle();
        chk("R7 level active low", 32'(irq_o), 0);
        irq_pol = 1'b1; pend_clr = '1;
        cycle();
        chk("R7 idle after clear", 32'(irq_o), 0);

        // R8 edge latch outlives source
        quiet(); irq_edge = 1'b1; ev_carry[0] = 1'b1;
        cycle();
        chk("R8 latch not yet", 32'(irq_o), 0);
        quiet();
        cycle();
        chk("R8 latch set", 32'(irq_o), 1);
        pend_clr = '1;
        cycle();
        chk("R8 latch holds after source cleared", 32'(irq_o), 1);
        quiet(); irq_clr = 1'b1;
        cycle();
        chk("R8 strobe clears latch", 32'(irq_o), 0);
        quiet(); irq_edge = 1'b0;
        cycle();

        // random phase
        for (int n = 0; n < 600; n++) begin
            ev_carry   = NCH'($urandom & $urandom);
            ev_borrow  = NCH'($urandom & $urandom);
            ev_compare = NCH'($urandom & $urandom);
            ev_error   = NCH'($urandom & $urandom & $urandom);
            dir_up     = NCH'($urandom);
            idx_in     = NCH'($urandom);
            flag_clr   = NCH'($urandom & $urandom & $urandom);
            err_clr    = NCH'($urandom & $urandom & $urandom);
            pend_clr   = NCH'($urandom & $urandom);
            irq_mask   = NCH'($urandom & $urandom);
            irq_clr    = ($urandom % 6) == 0;
            status_sel = SELW'($urandom);
            if ((n % 50) == 0) begin
                flag_mode = 8'($urandom);
                route_cfg = 8'($urandom);
                irq_en    = ($urandom % 4) != 0;
                irq_pol   = 1'($urandom);
                irq_edge  = 1'($urandom);
            end
            cycle();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule